// File: doc/BRIEF.md
# DDR SDRAM Command Legality Checker

This block watches the command pins of a four-bank DDR SDRAM interface once per clock. It never drives the memory. Each cycle it decodes the command from clock enable, chip select, the three active-low strobes (row, column, write), the two bank-select bits and the auto-precharge address bit. It keeps a per-bank record of whether a row is open. A set of down-counters measures the spacing between commands.

When a command breaks an ordering rule or comes too early for a minimum delay, the block raises a one-cycle error pulse with a 4-bit code naming the rule. Every minimum delay is an input given in clock cycles, so the same instance can check any speed grade. A flagged command is treated as if it never happened, so a single mistake does not cause a string of further reports.

Top module: `ddr_cmd_checker`

## Requirements
- R1: A command is decoded only when `cke` is high and `cs_n` is low. Otherwise the cycle raises no error and changes no state. Decoding uses {ras_n,cas_n,we_n}: 000 mode set, 001 refresh, 011 activate, 101 read, 100 write, 010 precharge, 110 burst stop, 111 no operation.
- R2: `ba` selects the bank as a binary index 0 to 3. An accepted activate opens that bank. A read or write to a bank that is not open gives code 4. An activate to a bank that is already open gives code 5.
- R3: A precharge with `addr_ap` high closes every bank and ignores `ba`. With `addr_ap` low it closes only the selected bank.
- R4: A mode set or refresh while any bank is open gives code 2.
- R5: After an accepted mode set, any decoded command other than no operation that comes fewer than `t_mrd` cycles later gives code 1.
- R6: A read or write fewer than `t_rcd` cycles after the activate of its bank gives code 6.
- R7: An activate fewer than `t_rp` cycles after its bank was closed gives code 7.
- R8: An activate fewer than `t_rrd` cycles after an accepted activate to a different bank gives code 8.
- R9: A precharge that would close an open bank fewer than `t_ras` cycles after that bank's activate gives code 9.
- R10: An activate fewer than `t_rc` cycles after the previous activate of the same bank gives code 10.
- R11: A read or write with `addr_ap` high closes its bank. After a write with auto precharge, any read or write within `t_wburst` cycles gives code 3, and an activate to that bank needs `t_wburst + t_rp` cycles. After a read with auto precharge, the `t_rp` window starts at the command.
- R12: Errors are registered. `err_valid` is high for exactly the one cycle after the offending command, with one code. When several rules are broken, the lowest code wins. A flagged command changes no bank state and restarts no counter.
- R13: After reset all banks are idle, every timing window has expired and `err_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable pin as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank select |
| addr_ap | input | 1 | Address bit 10: auto precharge / precharge-all |
| t_rcd | input | TW | Activate to read/write, cycles |
| t_rp | input | TW | Precharge to activate, cycles |
| t_rrd | input | TW | Activate to activate on another bank, cycles |
| t_ras | input | TW | Activate to precharge, cycles |
| t_rc | input | TW | Activate to activate on the same bank, cycles |
| t_mrd | input | TW | Mode set to next command, cycles |
| t_wburst | input | TW | Write burst length in clock cycles |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 4 | Number of the broken rule, 0 when no error |

## Verification
The inputs are sampled at a rising edge, and the verdict for that command appears on `err_valid`/`err_code` right after the same edge, one register later. It holds for exactly that cycle. The bench drives every command on a falling edge and reads the outputs one time step after the next rising edge, so each reading belongs to the command just issued. Every timing rule is swept over gaps from one cycle up to past its limit, with a fresh reset before each gap. At each gap the expected code is worked out from the gap and the configured minimum, and where two rules could apply, from the priority order.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_MRS, CMD_REF, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_BST
  } cmd_e;

  typedef enum logic [3:0] {
    E_NONE      = 4'd0,
    E_MRD       = 4'd1,
    E_NOT_IDLE  = 4'd2,
    E_WAP       = 4'd3,
    E_IDLE_BANK = 4'd4,
    E_OPEN_BANK = 4'd5,
    E_RCD       = 4'd6,
    E_RP        = 4'd7,
    E_RRD       = 4'd8,
    E_RAS       = 4'd9,
    E_RC        = 4'd10
  } err_e;

  // Pin pattern to command; deselect and clock-disabled cycles are NOP.
  function automatic cmd_e decode_cmd(input logic cke, input logic cs_n,
                                      input logic ras_n, input logic cas_n,
                                      input logic we_n);
    cmd_e c;
    if (!cke || cs_n) c = CMD_NOP;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  c = CMD_MRS;
        3'b001:  c = CMD_REF;
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b110:  c = CMD_BST;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/ddr_wait_cnt.sv
module ddr_wait_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         busy
);
  logic [W-1:0] cnt;

  // Window of len cycles: the event cycle itself plus len-1 blocked cycles.
  function automatic logic [W-1:0] span(input logic [W-1:0] t);
    return (t == '0) ? '0 : t - W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= span(len);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);

  p_window_drains_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] t_rcd,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_ras,
  input  logic [TW-1:0] t_rc,
  input  logic [TW:0]   wb_rp,
  input  logic          act_i,
  input  logic          pre_i,
  input  logic          rdap_i,
  input  logic          wrap_i,
  output logic          open_o,
  output logic          rcd_busy,
  output logic          rp_busy,
  output logic          ras_busy,
  output logic          rc_busy
);
  localparam int CW = TW + 1;

  logic          close_ev;
  logic [CW-1:0] rp_len;

  assign close_ev = pre_i | rdap_i | wrap_i;
  assign rp_len   = wrap_i ? wb_rp : {1'b0, t_rp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        open_o <= 1'b0;
    else if (act_i)    open_o <= 1'b1;
    else if (close_ev) open_o <= 1'b0;
  end

  ddr_wait_cnt #(.W(CW)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_i),
    .len({1'b0, t_rcd}), .busy(rcd_busy));
  ddr_wait_cnt #(.W(CW)) u_ras (.clk(clk), .rst_n(rst_n), .load(act_i),
    .len({1'b0, t_ras}), .busy(ras_busy));
  ddr_wait_cnt #(.W(CW)) u_rc  (.clk(clk), .rst_n(rst_n), .load(act_i),
    .len({1'b0, t_rc}),  .busy(rc_busy));
  ddr_wait_cnt #(.W(CW)) u_rp  (.clk(clk), .rst_n(rst_n), .load(close_ev),
    .len(rp_len),        .busy(rp_busy));

  p_no_act_and_close_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_i && close_ev));

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddr_chk_pkg::*;
#(
  parameter int TW   = 6,
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            addr_ap,
  input  logic [TW-1:0]   t_rcd,
  input  logic [TW-1:0]   t_rp,
  input  logic [TW-1:0]   t_rrd,
  input  logic [TW-1:0]   t_ras,
  input  logic [TW-1:0]   t_rc,
  input  logic [TW-1:0]   t_mrd,
  input  logic [TW-1:0]   t_wburst,
  output logic            err_valid,
  output logic [3:0]      err_code
);
  localparam int NB = 1 << BA_W;
  localparam int CW = TW + 1;

  cmd_e            cmd;
  err_e            err_n;
  logic            is_rw, acc;
  logic [NB-1:0]   open_q, rcd_b, rp_b, ras_b, rc_b, tgt;
  logic [NB-1:0]   act_s, pre_s, rdap_s, wrap_s;
  logic            rrd_busy, mrd_busy, wap_busy;
  logic [BA_W-1:0] last_act;
  logic [CW-1:0]   wb_rp;

  assign cmd   = decode_cmd(cke, cs_n, ras_n, cas_n, we_n);
  assign is_rw = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign wb_rp = {1'b0, t_wburst} + {1'b0, t_rp};
  assign tgt   = addr_ap ? {NB{1'b1}} : (NB'(1) << ba);

  // Rule check in priority order: the lowest code wins.
  always_comb begin
    err_n = E_NONE;
    if (cmd != CMD_NOP && mrd_busy)                           err_n = E_MRD;
    else if ((cmd == CMD_MRS || cmd == CMD_REF) && |open_q)   err_n = E_NOT_IDLE;
    else if (is_rw && wap_busy)                               err_n = E_WAP;
    else if (is_rw && !open_q[ba])                            err_n = E_IDLE_BANK;
    else if (cmd == CMD_ACT && open_q[ba])                    err_n = E_OPEN_BANK;
    else if (is_rw && rcd_b[ba])                              err_n = E_RCD;
    else if (cmd == CMD_ACT && rp_b[ba])                      err_n = E_RP;
    else if (cmd == CMD_ACT && rrd_busy && last_act != ba)    err_n = E_RRD;
    else if (cmd == CMD_PRE && |(ras_b & open_q & tgt))       err_n = E_RAS;
    else if (cmd == CMD_ACT && rc_b[ba])                      err_n = E_RC;
  end

  assign acc = (cmd != CMD_NOP) && (err_n == E_NONE);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign act_s[b]  = acc && cmd == CMD_ACT && ba == BA_W'(b);
    assign pre_s[b]  = acc && cmd == CMD_PRE && tgt[b] && open_q[b];
    assign rdap_s[b] = acc && cmd == CMD_RD && addr_ap && ba == BA_W'(b);
    assign wrap_s[b] = acc && cmd == CMD_WR && addr_ap && ba == BA_W'(b);

    ddr_bank_track #(.TW(TW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_rc(t_rc), .wb_rp(wb_rp),
      .act_i(act_s[b]), .pre_i(pre_s[b]), .rdap_i(rdap_s[b]), .wrap_i(wrap_s[b]),
      .open_o(open_q[b]), .rcd_busy(rcd_b[b]), .rp_busy(rp_b[b]),
      .ras_busy(ras_b[b]), .rc_busy(rc_b[b]));
  end

  ddr_wait_cnt #(.W(CW)) u_rrd (.clk(clk), .rst_n(rst_n), .load(|act_s),
    .len({1'b0, t_rrd}), .busy(rrd_busy));
  ddr_wait_cnt #(.W(CW)) u_mrd (.clk(clk), .rst_n(rst_n),
    .load(acc && cmd == CMD_MRS), .len({1'b0, t_mrd}), .busy(mrd_busy));
  ddr_wait_cnt #(.W(CW)) u_wap (.clk(clk), .rst_n(rst_n), .load(|wrap_s),
    .len({1'b0, t_wburst}), .busy(wap_busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_act <= '0;
    else if (|act_s) last_act <= ba;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_code  <= 4'd0;
    end else begin
      err_valid <= (err_n != E_NONE);
      err_code  <= err_n;
    end
  end

  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke) |=> !err_valid);

  p_activate_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd == CMD_ACT) |=> open_q[$past(ba)]);

  p_precharge_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd == CMD_PRE && addr_ap) |=> (open_q == '0));

  p_busy_mode_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_MRS || cmd == CMD_REF) && open_q != '0 && !mrd_busy)
      |=> (err_valid && err_code == 4'd2));

  p_rejected_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP && err_n != E_NONE) |=> (open_q == $past(open_q)));

endmodule

// File: tb/test_ddr_cmd_checker.sv
module test_ddr_cmd_checker;
  localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_ACT = 3'b011,
                         P_RD  = 3'b101, P_WR  = 3'b100, P_PRE = 3'b010,
                         P_BST = 3'b110, P_NOP = 3'b111;
  localparam int T_RCD = 3, T_RP = 3, T_RRD = 2, T_RAS = 6, T_RC = 10,
                 T_MRD = 2, T_WB = 4;

  logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic addr_ap = 0;
  logic err_valid;
  logic [3:0] err_code;
  logic got_v;
  logic [3:0] got_c;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ddr_cmd_checker i_ddr_cmd_checker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr_ap(addr_ap),
    .t_rcd(6'(T_RCD)), .t_rp(6'(T_RP)), .t_rrd(6'(T_RRD)), .t_ras(6'(T_RAS)),
    .t_rc(6'(T_RC)), .t_mrd(6'(T_MRD)), .t_wburst(6'(T_WB)),
    .err_valid(err_valid), .err_code(err_code));

  task automatic issue(input logic [2:0] p, input int b = 0, input logic ap = 0,
                       input logic cs = 0, input logic ck = 1);
    @(negedge clk);
    {ras_n, cas_n, we_n} = p;
    cs_n = cs; cke = ck; ba = 2'(b); addr_ap = ap;
    @(posedge clk);
    #1;
    got_v = err_valid;
    got_c = err_code;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(P_NOP);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cs_n = 1; cke = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic chk(input string req, input logic ev, input int ec);
    checks++;
    if (got_v !== ev || (ev && got_c !== 4'(ec))) begin
      errors++;
      $display("FAIL %s: got valid=%0b code=%0d, expected valid=%0b code=%0d",
               req, got_v, got_c, ev, ec);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R13: reset state, windows expired
    do_reset();
    #1; got_v = err_valid; got_c = err_code;
    chk("R13 reset idle", 0, 0);
    issue(P_ACT, 0);       chk("R13 act right after reset", 0, 0);
    issue(P_RD, 2);        chk("R13 other bank idle", 1, 4);

    // R1: deselect and clock-disabled cycles are ignored
    do_reset();
    issue(P_RD, 0, 0, 1);  chk("R1 deselect read", 0, 0);
    issue(P_RD, 0, 0, 0, 0); chk("R1 cke low read", 0, 0);
    issue(P_ACT, 0, 0, 1); chk("R1 deselect act", 0, 0);
    nops(3);
    issue(P_RD, 0);        chk("R1 deselect act left bank idle", 1, 4);
    issue(P_BST, 0);       chk("R1 burst stop legal", 0, 0);
    issue(P_NOP, 0);       chk("R1 nop legal", 0, 0);

    // R2: bank mapping, idle and open bank rules
    for (int b = 0; b < 4; b++) begin
      do_reset();
      issue(P_ACT, b);
      nops(T_RCD);
      for (int j = 0; j < 4; j++) begin
        issue(P_RD, j);
        chk($sformatf("R2 read bank %0d after act %0d", j, b), j != b, 4);
      end
      issue(P_ACT, b);     chk("R2 act open bank", 1, 5);
    end

    // R3: precharge all vs single bank
    for (int all = 0; all < 2; all++) begin
      do_reset();
      issue(P_ACT, 0); issue(P_NOP);
      issue(P_ACT, 1); issue(P_NOP);
      issue(P_ACT, 2); issue(P_NOP);
      issue(P_ACT, 3);
      nops(T_RAS);
      issue(P_PRE, all ? 0 : 2, all != 0);
      chk("R3 precharge accepted", 0, 0);
      for (int j = 0; j < 4; j++) begin
        issue(P_RD, j);
        chk($sformatf("R3 read bank %0d all=%0d", j, all), (all != 0) || j == 2, 4);
      end
    end

    // R4: mode set / refresh need all banks idle
    do_reset();
    issue(P_ACT, 1);
    issue(P_REF);          chk("R4 refresh with open bank", 1, 2);
    issue(P_MRS);          chk("R4 mode set with open bank", 1, 2);
    nops(T_RAS - 3);
    issue(P_PRE, 1);       chk("R4 precharge", 0, 0);
    nops(T_RP - 1);
    issue(P_REF);          chk("R4 refresh all idle", 0, 0);

    // R5: mode set spacing
    for (int d = 1; d <= 3; d++) begin
      do_reset();
      issue(P_MRS);
      nops(d - 1);
      issue(P_ACT, 0);
      chk($sformatf("R5 act gap %0d", d), d < T_MRD, 1);
    end
    do_reset();
    issue(P_MRS); issue(P_NOP); chk("R5 nop after mode set", 0, 0);
    do_reset();
    issue(P_MRS); issue(P_BST); chk("R5 burst stop after mode set", 1, 1);

    // R6: activate to read
    for (int d = 1; d <= 5; d++) begin
      do_reset();
      issue(P_ACT, 0); nops(d - 1); issue(P_RD, 0);
      chk($sformatf("R6 read gap %0d", d), d < T_RCD, 6);
    end

    // R9: activate to precharge
    for (int d = 1; d <= 8; d++) begin
      do_reset();
      issue(P_ACT, 0); nops(d - 1); issue(P_PRE, 0);
      chk($sformatf("R9 precharge gap %0d", d), d < T_RAS, 9);
    end

    // R7: precharge to activate
    for (int e = 1; e <= 5; e++) begin
      do_reset();
      issue(P_ACT, 0); nops(T_RAS); issue(P_PRE, 0);
      nops(e - 1); issue(P_ACT, 0);
      chk($sformatf("R7 act gap %0d", e), e < T_RP, 7);
    end

    // R10: activate to activate same bank
    for (int e = 3; e <= 5; e++) begin
      do_reset();
      issue(P_ACT, 0); nops(T_RAS - 1); issue(P_PRE, 0);
      nops(e - 1); issue(P_ACT, 0);
      chk($sformatf("R10 act gap %0d", T_RAS + e), (T_RAS + e) < T_RC, 10);
    end

    // R8: activate to activate, different banks
    for (int d = 1; d <= 3; d++) begin
      do_reset();
      issue(P_ACT, 0); nops(d - 1); issue(P_ACT, 1);
      chk($sformatf("R8 act gap %0d", d), d < T_RRD, 8);
    end

    // R11: write with auto precharge
    for (int g = 1; g <= 6; g++) begin
      do_reset();
      issue(P_ACT, 1); issue(P_NOP); issue(P_ACT, 0); nops(2);
      issue(P_WR, 0, 1);   chk("R11 write auto precharge", 0, 0);
      nops(g - 1); issue(P_RD, 1);
      chk($sformatf("R11 read during burst gap %0d", g), g < T_WB, 3);
    end
    for (int h = 1; h <= 8; h++) begin
      do_reset();
      issue(P_ACT, 1); issue(P_NOP); issue(P_ACT, 0); nops(2);
      issue(P_WR, 0, 1);
      nops(h - 1); issue(P_ACT, 0);
      chk($sformatf("R11 act after write-ap gap %0d", h), h < T_WB + T_RP, 7);
    end
    do_reset();
    issue(P_ACT, 0); nops(T_RCD - 1);
    issue(P_RD, 0, 1);     chk("R11 read auto precharge", 0, 0);
    issue(P_RD, 0);        chk("R11 read-ap closed bank", 1, 4);

    // R12: priority, pulse width, rejected command has no effect
    do_reset();
    issue(P_ACT, 0);
    issue(P_ACT, 0);       chk("R12 priority open over rc", 1, 5);
    issue(P_NOP);          chk("R12 single-cycle pulse", 0, 0);
    do_reset();
    issue(P_ACT, 0);
    issue(P_ACT, 1);       chk("R12 rejected act", 1, 8);
    nops(4);
    issue(P_RD, 1);        chk("R12 rejected act left bank idle", 1, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule